// File: doc/BRIEF.md
# Secondary-Sync Control Word Exchanger

This block sits beside the slave side of a codec serial port. It exchanges 16-bit control words with the codec in a secondary sync slot in the middle of each frame, not in fixed slots. A host that wants to send a control word writes it into the block. The block then announces the request inside the audio stream: the lowest bit of each outgoing audio word is 1 while a request is pending and 0 otherwise. The codec answers by pulsing the frame sync a second time, half a frame after the ordinary pulse.

All serial timing is counted in bit periods. The codec supplies the bit clock, and the block sees it as a one-cycle strobe, `bit_tick_i`. A frame position counter tells an ordinary sync from a secondary one. A sync in any other position is reported as an error. On a secondary sync the block shifts the pending control word out MSB first, or zeros if nothing is pending. In the same 16 bit periods it captures the codec's control word into a receive register with a valid flag that the host clears by reading it. A second host write made while a request is outstanding is parked until the outstanding word has gone out.

Top module: `sfs_ctrl_port`

## Requirements
- R1: With no control request pending, the audio word loaded at an ordinary sync appears on `txd_o` MSB first, one bit per bit period, in the 16 bit periods that follow the sync tick, with its bit 0 forced to 0.
- R2: After a host write through `ctrl_wr_i`, every audio word loaded while the request is still pending goes out with its bit 0 forced to 1.
- R3: The first sync after reset is taken as ordinary and fixes the frame position. After that, a sync at position 0 is ordinary, a sync at position FRAME_BITS/2 is secondary, and a sync at any other position starts no transfer and raises `sync_err_o` for one clock, visible right after that bit tick.
- R4: On a secondary sync with a request pending, the pending control word appears on `txd_o` MSB first in the 16 bit periods following the sync tick.
- R5: On a secondary sync with no request pending, `txd_o` stays 0 for those 16 bit periods.
- R6: After every secondary sync, `rxd_i` is sampled on each of the next 16 bit ticks, MSB first. The assembled word is placed on `ctrl_rdata_o` and `ctrl_rvalid_o` is set, whether or not a request was pending.
- R7: A `ctrl_rd_i` strobe clears `ctrl_rvalid_o`. If the strobe arrives in the same cycle as a capture, the flag stays set.
- R8: A pending request is retired when the bit period of its last control bit ends. Audio words loaded after that carry bit 0 = 0.
- R9: A host write made while a request is pending is held back. It becomes the pending request once the current word has been shifted out, and it is sent at the next secondary sync.
- R10: Outside the audio and control shift windows, `txd_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle strobe per serial bit period |
| sync_i | input | 1 | Frame sync from the codec, sampled on bit ticks |
| rxd_i | input | 1 | Serial receive data, sampled on bit ticks |
| txd_o | output | 1 | Serial transmit data, updated after each bit tick |
| aud_tx_i | input | 16 | Audio word loaded at an ordinary sync |
| ctrl_wr_i | input | 1 | Host write strobe for the control word to send |
| ctrl_wdata_i | input | 16 | Control word to send |
| ctrl_rd_i | input | 1 | Host read strobe for the received control word |
| ctrl_rdata_o | output | 16 | Last received control word |
| ctrl_rvalid_o | output | 1 | Received control word not yet read |
| sync_err_o | output | 1 | One-clock pulse on a sync at an unexpected position |

## Verification
The assertions take for granted that bit ticks are spaced at least two clocks apart. They also assume that FRAME_BITS leaves room after each 16-bit window, so that no new sync arrives while an audio or control word is still shifting. On those terms, a shifter load is always followed by an untouched shift run, and every capture ends with a receive counter of one. The stimulus issues each tick in one clock and holds the next clock idle. It places syncs only at frame start, at mid-frame, or at a misplaced position in the idle tail of the frame. Host writes, reads and random frame contents are issued only in the idle clocks between ticks, except for the directed read that lands on the capture tick.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int CW = 16;
    localparam int LW = $clog2(CW + 1);

    typedef struct packed {
        logic [CW-1:0] sh;
        logic [LW-1:0] left;
        logic          txd;
        logic          ctl_act;
        logic [CW-2:0] rx_sh;
        logic [LW-1:0] rx_left;
        logic [CW-1:0] rx_word;
        logic          rx_vld;
    } eng_t;

    typedef struct packed {
        logic          pend;
        logic [CW-1:0] word;
        logic          hold_v;
        logic [CW-1:0] hold;
    } req_t;
endpackage

// File: rtl/sfs_sync_classifier.sv
module sfs_sync_classifier #(
    parameter int FRAME_BITS = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sync_i,
    output logic norm_o,
    output logic sec_o,
    output logic err_o
);
    localparam int PW   = $clog2(FRAME_BITS);
    localparam int HALF = FRAME_BITS / 2;

    typedef struct packed {
        logic [PW-1:0] pos;
        logic          locked;
        logic          err;
    } cls_t;

    cls_t q, d;
    logic misplaced;

    always_comb begin
        d         = q;
        d.err     = 1'b0;
        norm_o    = tick_i && sync_i && (!q.locked || q.pos == '0);
        sec_o     = tick_i && sync_i && q.locked && q.pos == PW'(HALF);
        misplaced = tick_i && sync_i && q.locked && q.pos != '0 && q.pos != PW'(HALF);
        if (tick_i) begin
            if (norm_o) begin
                d.pos    = PW'(1);
                d.locked = 1'b1;
            end else if (q.pos == PW'(FRAME_BITS - 1)) begin
                d.pos = '0;
            end else begin
                d.pos = q.pos + PW'(1);
            end
            if (misplaced) d.err = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign err_o = q.err;

    // R3
    norm_realign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        norm_o |=> (q.pos == PW'(1) && q.locked));
    // R3
    err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> $past(tick_i && sync_i));
endmodule

// File: rtl/sfs_req_queue.sv
module sfs_req_queue
    import sfs_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          done_i,
    output logic          pend_o,
    output logic [CW-1:0] word_o
);
    req_t q, d;

    always_comb begin
        d = q;
        if (done_i) begin
            d.pend   = q.hold_v;
            d.word   = q.hold;
            d.hold_v = 1'b0;
        end
        if (wr_i) begin
            if (d.pend) begin
                d.hold_v = 1'b1;
                d.hold   = wdata_i;
            end else begin
                d.pend = 1'b1;
                d.word = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign pend_o = q.pend;
    assign word_o = q.word;

    // R8
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !q.hold_v && !wr_i) |=> !q.pend);
    // R9
    hold_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.hold_v |-> q.pend);
endmodule

// File: rtl/sfs_serial_engine.sv
module sfs_serial_engine
    import sfs_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          norm_i,
    input  logic          sec_i,
    input  logic [CW-1:0] aud_i,
    input  logic          tag_i,
    input  logic          pend_i,
    input  logic [CW-1:0] ctrl_word_i,
    input  logic          rxd_i,
    input  logic          rd_i,
    output logic          txd_o,
    output logic          done_o,
    output logic [CW-1:0] rx_word_o,
    output logic          rx_vld_o
);
    eng_t q, d;
    logic [CW-1:0] ld;
    logic          cap;

    always_comb begin
        d      = q;
        ld     = '0;
        done_o = tick_i && q.left == '0 && q.ctl_act && !norm_i && !sec_i;
        cap    = tick_i && !sec_i && q.rx_left == LW'(1);

        // transmit side
        if (tick_i) begin
            if (norm_i || sec_i) begin
                if (norm_i)      ld = (aud_i & ~CW'(1)) | CW'(tag_i);
                else if (pend_i) ld = ctrl_word_i;
                d.txd     = ld[CW-1];
                d.sh      = {ld[CW-2:0], 1'b0};
                d.left    = LW'(CW - 1);
                d.ctl_act = sec_i && pend_i;
            end else if (q.left != '0) begin
                d.txd  = q.sh[CW-1];
                d.sh   = {q.sh[CW-2:0], 1'b0};
                d.left = q.left - LW'(1);
            end else begin
                d.txd     = 1'b0;
                d.ctl_act = 1'b0;
            end
        end

        // receive side
        if (rd_i) d.rx_vld = 1'b0;
        if (tick_i && sec_i) begin
            d.rx_left = LW'(CW);
        end else if (tick_i && q.rx_left != '0) begin
            d.rx_sh   = {q.rx_sh[CW-3:0], rxd_i};
            d.rx_left = q.rx_left - LW'(1);
            if (cap) begin
                d.rx_word = {q.rx_sh, rxd_i};
                d.rx_vld  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign txd_o     = q.txd;
    assign rx_word_o = q.rx_word;
    assign rx_vld_o  = q.rx_vld;

    // R1
    tag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && norm_i) |=> (q.sh[1] == $past(tag_i)));
    // R5
    idle_ctrl_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && sec_i && !pend_i) |=> (q.sh == '0 && !q.txd && !q.ctl_act));
    // R6
    cap_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.rx_vld) |-> ($past(q.rx_left) == LW'(1)));
    // R7
    rd_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !cap) |=> !q.rx_vld);
endmodule

// File: rtl/sfs_ctrl_port.sv
module sfs_ctrl_port
    import sfs_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bit_tick_i,
    input  logic        sync_i,
    input  logic        rxd_i,
    output logic        txd_o,
    input  logic [15:0] aud_tx_i,
    input  logic        ctrl_wr_i,
    input  logic [15:0] ctrl_wdata_i,
    input  logic        ctrl_rd_i,
    output logic [15:0] ctrl_rdata_o,
    output logic        ctrl_rvalid_o,
    output logic        sync_err_o
);
    logic          norm, sec, done, pend;
    logic [CW-1:0] pend_word;

    sfs_sync_classifier #(.FRAME_BITS(FRAME_BITS)) u_cls (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (bit_tick_i),
        .sync_i (sync_i),
        .norm_o (norm),
        .sec_o  (sec),
        .err_o  (sync_err_o)
    );

    sfs_req_queue u_req (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (ctrl_wr_i),
        .wdata_i (ctrl_wdata_i),
        .done_i  (done),
        .pend_o  (pend),
        .word_o  (pend_word)
    );

    sfs_serial_engine u_eng (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (bit_tick_i),
        .norm_i      (norm),
        .sec_i       (sec),
        .aud_i       (aud_tx_i),
        .tag_i       (pend),
        .pend_i      (pend),
        .ctrl_word_i (pend_word),
        .rxd_i       (rxd_i),
        .rd_i        (ctrl_rd_i),
        .txd_o       (txd_o),
        .done_o      (done),
        .rx_word_o   (ctrl_rdata_o),
        .rx_vld_o    (ctrl_rvalid_o)
    );
endmodule

// File: tb/sfs_ctrl_port_tb.sv
`timescale 1ns/1ps
module sfs_ctrl_port_tb;
    localparam int FB   = 64;
    localparam int HALF = FB / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, sync = 1'b0, rxd = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [15:0] aud = '0, wdata = '0;
    logic        txd, rvalid, err;
    logic [15:0] rdata;

    int checks = 0;
    int fails  = 0;

    // bench model of the request state
    logic        m_pend = 1'b0, m_hold_v = 1'b0;
    logic [15:0] m_word = '0, m_hold = '0;

    always #4 clk = ~clk;

    sfs_ctrl_port #(.FRAME_BITS(FB)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .sync_i(sync), .rxd_i(rxd),
        .txd_o(txd), .aud_tx_i(aud), .ctrl_wr_i(wr), .ctrl_wdata_i(wdata),
        .ctrl_rd_i(rd), .ctrl_rdata_o(rdata), .ctrl_rvalid_o(rvalid), .sync_err_o(err)
    );

    function automatic logic [15:0] exp_audio(input logic [15:0] a, input logic tag);
        return {a[15:1], tag};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [15:0] v);
        if (m_pend) begin m_hold_v = 1'b1; m_hold = v; end
        else begin m_pend = 1'b1; m_word = v; end
    endtask

    task automatic host_write(input logic [15:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic step(input logic s, input logic r, input logic do_rd,
                        output logic t_seen, output logic e_seen);
        @(negedge clk); tick = 1'b1; sync = s; rxd = r; rd = do_rd;
        @(negedge clk); tick = 1'b0; sync = 1'b0; rd = 1'b0;
        t_seen = txd; e_seen = err;
    endtask

    task automatic run_frame(input logic [15:0] a, input logic sec, input logic [15:0] rxw,
                             input logic rd_cap, input logic wr_mid, input logic [15:0] wmid,
                             input int err_pos);
        logic        was_pend = m_pend;
        logic [15:0] exp_ctrl = (sec && m_pend) ? m_word : 16'h0;
        logic [15:0] aud_out = '0, ctrl_out = '0;
        logic        idle_bad = 1'b0, err_bad = 1'b0, err_hit = 1'b0;
        logic        t, e;
        aud = a;
        for (int p = 0; p < FB; p++) begin
            logic s = (p == 0) || (sec && p == HALF) || (p == err_pos);
            logic r = (p > HALF && p <= HALF + 16) ? rxw[HALF + 16 - p] : 1'($urandom % 2);
            step(s, r, rd_cap && (p == HALF + 16), t, e);
            if (p < 16)                          aud_out  = {aud_out[14:0], t};
            else if (p >= HALF && p < HALF + 16) ctrl_out = {ctrl_out[14:0], t};
            else if (t)                          idle_bad = 1'b1;
            if (p == err_pos) err_hit = e;
            else if (e)       err_bad = 1'b1;
            if (wr_mid && p == HALF + 4) host_write(wmid);
        end
        check("R1/R2 audio word with request tag", aud_out, exp_audio(a, was_pend));
        check(sec ? (was_pend ? "R4 control word out" : "R5 zeros without request")
                  : "R10 no control window", ctrl_out, exp_ctrl);
        check("R10 idle line low", 16'(idle_bad), 16'h0);
        check("R3 no spurious sync error", 16'(err_bad), 16'h0);
        if (err_pos >= 0) check("R3 misplaced sync error pulse", 16'(err_hit), 16'h1);
        if (wr_mid) model_write(wmid);
        if (sec && was_pend) begin
            m_pend = m_hold_v; m_word = m_hold; m_hold_v = 1'b0;
        end
        if (sec) begin
            check("R6 capture valid", 16'(rvalid), 16'h1);
            check("R6 captured word", rdata, rxw);
            if (rd_cap) check("R7 capture wins over read", 16'(rvalid), 16'h1);
            host_read();
            check("R7 read clears valid", 16'(rvalid), 16'h0);
        end else begin
            check("R6 no capture without secondary sync", 16'(rvalid), 16'h0);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f3c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset txd", 16'(txd), 16'h0);
        check("R6 reset valid", 16'(rvalid), 16'h0);
        check("R3 reset err", 16'(err), 16'h0);

        // R1 R5 R6: no request, secondary present
        run_frame(16'h8001, 1'b1, 16'hA5C3, 1'b0, 1'b0, 16'h0, -1);
        // R2 R4
        host_write(16'h1234); model_write(16'h1234);
        run_frame(16'h7FFF, 1'b1, 16'h0F0F, 1'b0, 1'b0, 16'h0, -1);
        // R8: request retired
        run_frame(16'hFFFF, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, -1);
        // R9: write during transfer is held
        host_write(16'hBEEF); model_write(16'hBEEF);
        run_frame(16'h5555, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0, -1);
        run_frame(16'hAAAA, 1'b1, 16'h3C3C, 1'b0, 1'b1, 16'hCAFE, -1);
        run_frame(16'h1111, 1'b1, 16'hFFFF, 1'b0, 1'b0, 16'h0, -1);
        run_frame(16'h2222, 1'b1, 16'h0001, 1'b0, 1'b0, 16'h0, -1);
        // R7: read on capture tick
        run_frame(16'h3333, 1'b1, 16'h8000, 1'b1, 1'b0, 16'h0, -1);
        // R3: misplaced sync in the idle tail
        run_frame(16'h4444, 1'b1, 16'h1357, 1'b0, 1'b0, 16'h0, 52);

        for (int i = 0; i < 16; i++) begin
            logic [15:0] v = 16'($urandom);
            if ($urandom % 2 == 0) begin host_write(v); model_write(v); end
            run_frame(16'($urandom), ($urandom % 4) != 0, 16'($urandom), 1'b0,
                      ($urandom % 4) == 0, 16'($urandom), ($urandom % 8 == 0) ? 56 : -1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule